// File: doc/BRIEF.md
# Run-time programmable serial delay line

This block delays a data word by a number of clock cycles that can be changed while it runs. Words enter one at a time at the serial input. They move one position down a chain of storage stages on each clock edge where shifting is enabled. A tap address picks which stage drives the output, so the delay seen at the output is the tap address plus one enabled shift.

The chain is built from four identical 32-stage segments placed end to end, which gives 128 stages. The two upper tap-address bits pick the segment and the five lower bits pick the stage inside it. A separate cascade output always shows the deepest stage, so several instances can be joined into longer lines. There is no reset and no parallel load. Stage contents are meaningless until enough enabled shifts have filled the depth in use.

The block is meant for balancing pipelines. A fixed tap gives a constant delay, for example 17 cycles on a wide bus so that it lines up with a slower parallel branch. A tap that changes at run time gives an elastic buffer.

Top module: `tap_delay_chain`

## Requirements
- R1: After at least `tap_sel`+1 enabled shifts, `dout` equals the `din` word captured `tap_sel`+1 enabled shifts earlier, for every tap value 0 to 127.
- R2: A change on `tap_sel` changes `dout` to the newly selected stage in the same cycle, without a clock edge.
- R3: On a rising edge with `shift_en` low, no stage changes. `dout` at any tap and `chain_out` keep their values.
- R4: Once 128 enabled shifts have occurred, `chain_out` equals the word captured 128 enabled shifts earlier, whatever the value of `tap_sel`.
- R5: `tap_sel`[6:5] selects the segment and `tap_sel`[4:0] selects the stage inside it. Taps 31/32, 63/64 and 95/96, which straddle segment boundaries, differ by exactly one enabled shift.
- R6: The tap may be changed between enabled shifts. The output then shows the word that is the new tap+1 shifts old, and the stored history is not disturbed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| shift_en | input | 1 | Active-high shift enable |
| din | input | DW (8) | Serial data word entering stage 0 |
| tap_sel | input | AW (7) | Output tap address; delay is tap_sel+1 |
| dout | output | DW (8) | Word at the selected stage |
| chain_out | output | DW (8) | Word at the deepest stage, for cascading |

## Verification
The hardest case to reach from the ports is a broad view of the stored history. At any clock edge only one tap can be seen, and every enabled edge moves all of the data. The bench fills the line and then holds `shift_en` low for several cycles. During that hold it sweeps `tap_sel` through all 128 taps, with several tap changes inside each clock period. This checks the combinational tap path and the hold behaviour together. In the running phases, shifts are gated off in an irregular pattern, and several boundary taps are probed between two edges.

// File: rtl/tap_delay_chain.sv
`timescale 1ns/1ps
module tap_delay_chain #(
  parameter int DW      = 8,
  parameter int STAGE_N = 32,
  parameter int UNIT_N  = 4,
  localparam int LW     = $clog2(STAGE_N),
  localparam int UW     = $clog2(UNIT_N),
  localparam int AW     = LW + UW
) (
  input  logic          clk,
  input  logic          shift_en,
  input  logic [DW-1:0] din,
  input  logic [AW-1:0] tap_sel,
  output logic [DW-1:0] dout,
  output logic [DW-1:0] chain_out
);
  localparam int TOTAL = STAGE_N * UNIT_N;
  localparam int CW    = $clog2(TOTAL + 1);

  logic [DW-1:0] mem [UNIT_N][STAGE_N];
  logic [DW-1:0] unit_tap [UNIT_N];
  logic [LW-1:0] tap_lo;
  logic [UW-1:0] tap_hi;

  assign tap_lo = tap_sel[LW-1:0];
  assign tap_hi = tap_sel[AW-1:LW];

  for (genvar u = 0; u < UNIT_N; u++) begin : g_unit
    for (genvar s = 0; s < STAGE_N; s++) begin : g_stage
      logic [DW-1:0] feed;
      if (s > 0) begin : g_inner
        assign feed = mem[u][s-1];
      end else if (u > 0) begin : g_link
        assign feed = mem[u-1][STAGE_N-1];
      end else begin : g_head
        assign feed = din;
      end
      always_ff @(posedge clk)
        if (shift_en) mem[u][s] <= feed;
    end
    assign unit_tap[u] = mem[u][tap_lo];
  end

  assign dout      = unit_tap[tap_hi];
  assign chain_out = mem[UNIT_N-1][STAGE_N-1];

  logic [CW-1:0] fill_q = '0;
  always_ff @(posedge clk)
    if (shift_en && fill_q != CW'(TOTAL)) fill_q <= fill_q + 1'b1;

  a_r1_entry: assert property (@(posedge clk) disable iff (fill_q == '0)
    shift_en |=> mem[0][0] == $past(din));

  a_r3_hold: assert property (@(posedge clk) disable iff (fill_q != CW'(TOTAL))
    !shift_en |=> $stable(chain_out) && $stable(mem[0][0]));

  a_r4_cascade: assert property (@(posedge clk) disable iff (fill_q != CW'(TOTAL))
    shift_en |=> chain_out == $past(mem[UNIT_N-1][STAGE_N-2]));

  always_comb begin
    if (fill_q == CW'(TOTAL) && tap_sel == '1)
      a_r4_top_tap: assert (dout == chain_out);
    if (fill_q == CW'(TOTAL) && tap_sel == '0)
      a_r2_tap_zero: assert (dout == mem[0][0]);
  end
endmodule

// File: tb/tb_tap_delay_chain.sv
`timescale 1ns/1ps
module tb_tap_delay_chain;
  localparam int DW = 8;
  localparam int AW = 7;
  localparam int TOTAL = 128;

  logic          clk = 1'b0;
  logic          shift_en = 1'b0;
  logic [DW-1:0] din = '0;
  logic [AW-1:0] tap_sel = '0;
  logic [DW-1:0] dout, chain_out;

  int checks = 0;
  int fails = 0;
  int n = 0;
  logic [DW-1:0] hist [1024];

  always #2 clk = ~clk;

  tap_delay_chain dut (
    .clk(clk), .shift_en(shift_en), .din(din),
    .tap_sel(tap_sel), .dout(dout), .chain_out(chain_out)
  );

  function automatic logic [DW-1:0] gen(input int k);
    return DW'(k * 29 + k / 5 + 3);
  endfunction

  task automatic chk(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h (shifts=%0d tap=%0d)", tag, act, exp, n, tap_sel);
    end
  endtask

  task automatic step(input logic en, input int tap, input string tag);
    @(negedge clk);
    din = gen(n);
    shift_en = en;
    tap_sel = AW'(tap);
    @(posedge clk);
    if (en) begin
      hist[n] = din;
      n++;
    end
    #1;
    if (n > tap) chk(tag, dout, hist[n-1-tap]);
    if (n >= TOTAL) chk("R4 chain_out", chain_out, hist[n-TOTAL]);
  endtask

  initial begin
    #(200000 * 4);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    // R1: fixed taps, continuous shifting
    for (int i = 0; i < 60; i++) step(1'b1, 0, "R1 tap0");
    for (int i = 0; i < 60; i++) step(1'b1, 16, "R1 tap16");
    for (int i = 0; i < 60; i++) step(1'b1, 127, "R1 tap127");
    // R6 + R3: tap changes every step, irregular enable gaps
    for (int i = 0; i < 240; i++) step(i % 3 != 2, (i * 7) % 128, "R6 moving tap");
    // R2 + R3: hold and sweep all taps combinationally
    @(negedge clk);
    shift_en = 1'b0;
    for (int t = 0; t < TOTAL; t++) begin
      tap_sel = AW'(t);
      #0.3;
      chk("R2 sweep", dout, hist[n-1-t]);
      chk("R3 hold chain_out", chain_out, hist[n-TOTAL]);
    end
    // R5: segment boundaries probed between edges
    for (int i = 0; i < 50; i++) begin
      step(i % 4 != 1, 31, "R5 tap31");
      foreach (tap_bnd[j]) begin
        tap_sel = AW'(tap_bnd[j]);
        #0.1;
        chk("R5 boundary", dout, hist[n-1-tap_bnd[j]]);
      end
    end
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  int tap_bnd [6] = '{32, 63, 64, 95, 96, 31};
endmodule